// File: doc/BRIEF.md
# CAN Frame Error Interrupt and Capture

This block sits beside a CAN protocol core and turns the core's frame-level error reports into a single maskable interrupt. Six kinds of fault are tracked: bus error, receive pre-buffer overflow, lost arbitration, error warning, error passive and bus off. Each has a sticky status flag and an enable bit. Any hardware event whose enable bit is set raises the frame error interrupt. Software can drop that interrupt only after it has cleared every status flag.

A bus error also carries an 8-bit code with the error kind, the direction and the position in the frame. The block stores this code in a capture register. After one capture the register locks, and it takes a new code only after software has read it. The same read is the only way to clear the bus error flag. The block also watches the receive pre-buffer. A start of frame that arrives while the buffer is still full counts as an overflow, and a discard signal then tells the receiver to ignore the bits of that frame.

Software reaches the block through a small register port with a chip select, a write strobe, a 2-bit address and 8-bit data. Read data is combinational.

Top module: `can_frame_err_irq`

## Requirements
- R1: Status bits are: 0 pre-buffer overflow, 1 arbitration lost, 2 error warning, 3 bus error, 4 error passive, 5 bus off. A one-cycle event pulse sets its flag from the next cycle, and the flag stays set.
- R2: An event whose enable bit (same position, register 1) is set raises the interrupt (bit 4 of register 2, and output `irq`) on the next cycle. An event with its enable bit clear does not raise it.
- R3: Writing 1 to bits 0, 1, 2, 4 or 5 of register 0 clears those flags. Writing to bit 3 has no effect. A hardware set in the same cycle as a clear wins.
- R4: Writing 1 to bit 4 of register 2 clears the interrupt only when all six status flags are already zero in that cycle. Otherwise the interrupt stays set. A new enabled event in the same cycle keeps it set.
- R5: The bus error flag clears only on a read of register 3.
- R6: When unlocked, a bus error stores its code in register 3 and locks it. The code is laid out as: [7:6] kind (00 bit, 01 form, 10 stuff, 11 other), [5] direction (0 transmit, 1 receive), [4:0] frame position (for example 00011 start of frame, 01011 data length code, 11001 ack slot, 11100 overload flag).
- R7: While the capture register is locked and is not being read, a further bus error sets flag 3 but leaves the stored code unchanged.
- R8: If a read of register 3 and a bus error fall in the same cycle, the read returns the old code, the new code is captured, and flag 3 is set again.
- R9: A start-of-frame pulse while `prebuf_full` is high sets flag 0 and raises `rx_drop` on the next cycle. `rx_drop` falls after a start-of-frame pulse with `prebuf_full` low.
- R10: After reset, all flags, enables, the interrupt, `rx_drop` and the capture code are zero, and capture is unlocked.
- R11: Register 1 reads back the six written enable bits. Unused read bits return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| berr_evt | input | 1 | Bus error event pulse |
| berr_code | input | 8 | Kind, direction and position of the bus error |
| arb_lost_evt | input | 1 | Arbitration lost pulse |
| warn_evt | input | 1 | Error warning pulse |
| passive_evt | input | 1 | Error passive pulse |
| busoff_evt | input | 1 | Bus off pulse |
| rx_sof | input | 1 | Start of a received frame |
| prebuf_full | input | 1 | Receive pre-buffer still holds an unprocessed frame |
| rx_drop | output | 1 | Receiver must ignore the current frame |
| reg_cs | input | 1 | Register access select |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| irq | output | 1 | Frame error interrupt |

## Verification
Directed sequences cover three cases. The first is a lone bus error followed by a second one while the capture register is locked, which separates a capturing register from one that overwrites. The second is a read that coincides with a new error, which shows the order of unlock and capture. The third is an attempted interrupt clear while a flag is still set, which checks the two-step gate. Random cycles then mix event pulses, enable patterns, write-1-clear masks and reads. This exposes wrong set-versus-clear priority and wrong enable masking, and each register read is compared against a bench model.

// File: rtl/can_ferr_pkg.sv
package can_ferr_pkg;
    localparam int NUM_COND = 6;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;

    localparam int IDX_OVF  = 0;
    localparam int IDX_ARB  = 1;
    localparam int IDX_WARN = 2;
    localparam int IDX_BERR = 3;
    localparam int IDX_PASV = 4;
    localparam int IDX_BOFF = 5;
    localparam int IRQ_BIT  = 4;

    localparam logic [ADDR_W-1:0] A_STATUS  = 2'd0;
    localparam logic [ADDR_W-1:0] A_ENABLE  = 2'd1;
    localparam logic [ADDR_W-1:0] A_IRQ     = 2'd2;
    localparam logic [ADDR_W-1:0] A_CAPTURE = 2'd3;

    typedef enum logic [1:0] {
        ET_BIT   = 2'b00,
        ET_FORM  = 2'b01,
        ET_STUFF = 2'b10,
        ET_OTHER = 2'b11
    } err_kind_e;

    typedef struct packed {
        err_kind_e   kind;
        logic        rx;
        logic [4:0]  pos;
    } err_code_t;
endpackage

// File: rtl/cferr_flags.sv
module cferr_flags #(
    parameter int N    = 6,
    parameter int BERR = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] w1c,
    input  logic         berr_rd,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    input  logic         irq_clr,
    output logic [N-1:0] status,
    output logic [N-1:0] enable,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] st;
        logic [N-1:0] en;
        logic         irq;
    } flags_t;

    flags_t s_d, s_q;
    logic [N-1:0] sw_mask;

    always_comb begin
        s_d = s_q;
        // bus error flag is not software-clearable by write
        sw_mask       = w1c;
        sw_mask[BERR] = 1'b0;
        s_d.st = s_q.st & ~sw_mask;
        if (berr_rd) begin
            s_d.st[BERR] = 1'b0;
        end
        // hardware set has priority over any clear
        s_d.st = s_d.st | hw_set;
        if (en_we) begin
            s_d.en = en_wdata;
        end
        // two-step clear: all flags must already be zero
        if (irq_clr && (s_q.st == '0)) begin
            s_d.irq = 1'b0;
        end
        if ((hw_set & s_q.en) != '0) begin
            s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status = s_q.st;
    assign enable = s_q.en;
    assign irq    = s_q.irq;
endmodule

// File: rtl/cferr_capture.sv
module cferr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         berr_evt,
    input  logic [W-1:0] code_in,
    input  logic         rd,
    output logic [W-1:0] code,
    output logic         locked
);
    typedef struct packed {
        logic [W-1:0] code;
        logic         lock;
    } cap_t;

    cap_t c_d, c_q;
    logic lock_after_rd;

    always_comb begin
        c_d = c_q;
        // a read unlocks first, so a same-cycle error is taken
        lock_after_rd = c_q.lock && !rd;
        c_d.lock = lock_after_rd;
        if (berr_evt && !lock_after_rd) begin
            c_d.code = code_in;
            c_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign code   = c_q.code;
    assign locked = c_q.lock;
endmodule

// File: rtl/cferr_rx_guard.sv
module cferr_rx_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic full,
    output logic overflow,
    output logic drop
);
    logic drop_d, drop_q;

    always_comb begin
        overflow = sof && full;
        drop_d   = drop_q;
        if (sof) begin
            drop_d = full;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else begin
            drop_q <= drop_d;
        end
    end

    assign drop = drop_q;
endmodule

// File: rtl/can_frame_err_irq.sv
module can_frame_err_irq
    import can_ferr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              berr_evt,
    input  logic [DATA_W-1:0] berr_code,
    input  logic              arb_lost_evt,
    input  logic              warn_evt,
    input  logic              passive_evt,
    input  logic              busoff_evt,
    input  logic              rx_sof,
    input  logic              prebuf_full,
    output logic              rx_drop,
    input  logic              reg_cs,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int PAD_W = DATA_W - NUM_COND;

    logic [NUM_COND-1:0] hw_set;
    logic [NUM_COND-1:0] status_q;
    logic [NUM_COND-1:0] enable_q;
    logic [NUM_COND-1:0] w1c;
    logic [DATA_W-1:0]   cap_code;
    logic                cap_lock;
    logic                cap_rd;
    logic                ovf_pulse;
    logic                st_wr;
    logic                en_wr;
    logic                irq_clr;

    cferr_rx_guard i_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (rx_sof),
        .full     (prebuf_full),
        .overflow (ovf_pulse),
        .drop     (rx_drop)
    );

    always_comb begin
        hw_set           = '0;
        hw_set[IDX_OVF]  = ovf_pulse;
        hw_set[IDX_ARB]  = arb_lost_evt;
        hw_set[IDX_WARN] = warn_evt;
        hw_set[IDX_BERR] = berr_evt;
        hw_set[IDX_PASV] = passive_evt;
        hw_set[IDX_BOFF] = busoff_evt;
    end

    always_comb begin
        st_wr   = reg_cs && reg_wr && (reg_addr == A_STATUS);
        en_wr   = reg_cs && reg_wr && (reg_addr == A_ENABLE);
        irq_clr = reg_cs && reg_wr && (reg_addr == A_IRQ) && reg_wdata[IRQ_BIT];
        cap_rd  = reg_cs && !reg_wr && (reg_addr == A_CAPTURE);
        w1c     = st_wr ? reg_wdata[NUM_COND-1:0] : '0;
    end

    cferr_flags #(
        .N    (NUM_COND),
        .BERR (IDX_BERR)
    ) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_set   (hw_set),
        .w1c      (w1c),
        .berr_rd  (cap_rd),
        .en_we    (en_wr),
        .en_wdata (reg_wdata[NUM_COND-1:0]),
        .irq_clr  (irq_clr),
        .status   (status_q),
        .enable   (enable_q),
        .irq      (irq)
    );

    cferr_capture #(
        .W (DATA_W)
    ) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .berr_evt (berr_evt),
        .code_in  (berr_code),
        .rd       (cap_rd),
        .code     (cap_code),
        .locked   (cap_lock)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_cs && !reg_wr) begin
            case (reg_addr)
                A_STATUS:  reg_rdata = {{PAD_W{1'b0}}, status_q};
                A_ENABLE:  reg_rdata = {{PAD_W{1'b0}}, enable_q};
                A_IRQ:     reg_rdata[IRQ_BIT] = irq;
                default:   reg_rdata = cap_code;
            endcase
        end
    end
endmodule

// File: rtl/cferr_checker.sv
module cferr_checker #(
    parameter int N    = 6,
    parameter int W    = 8,
    parameter int BERR = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] hw_set,
    input logic [N-1:0] status,
    input logic [N-1:0] enable,
    input logic         irq,
    input logic         berr_evt,
    input logic [W-1:0] berr_code,
    input logic [W-1:0] cap_code,
    input logic         cap_lock,
    input logic         cap_rd,
    input logic         rx_sof,
    input logic         prebuf_full,
    input logic         rx_drop
);
    p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((status & $past(hw_set)) == $past(hw_set)));

    p_irq_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_set & enable) != '0) |=> irq);

    p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (status != '0)) |=> irq);

    p_berr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BERR] && !cap_rd) |=> status[BERR]);

    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_evt && (!cap_lock || cap_rd)) |=> (cap_lock && (cap_code == $past(berr_code))));

    p_lock_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_lock && !cap_rd) |=> (cap_lock && $stable(cap_code)));

    p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && prebuf_full) |=> (rx_drop && status[0]));
endmodule

bind can_frame_err_irq cferr_checker #(
    .N    (can_ferr_pkg::NUM_COND),
    .W    (can_ferr_pkg::DATA_W),
    .BERR (can_ferr_pkg::IDX_BERR)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_set      (hw_set),
    .status      (status_q),
    .enable      (enable_q),
    .irq         (irq),
    .berr_evt    (berr_evt),
    .berr_code   (berr_code),
    .cap_code    (cap_code),
    .cap_lock    (cap_lock),
    .cap_rd      (cap_rd),
    .rx_sof      (rx_sof),
    .prebuf_full (prebuf_full),
    .rx_drop     (rx_drop)
);

// File: tb/test_can_frame_err_irq.sv
module test_can_frame_err_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       berr_evt = 1'b0;
    logic [7:0] berr_code = '0;
    logic       arb_lost_evt = 1'b0;
    logic       warn_evt = 1'b0;
    logic       passive_evt = 1'b0;
    logic       busoff_evt = 1'b0;
    logic       rx_sof = 1'b0;
    logic       prebuf_full = 1'b0;
    logic       rx_drop;
    logic       reg_cs = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [5:0] m_st, m_en;
    logic       m_irq, m_lock, m_drop;
    logic [7:0] m_cap;

    always #5 clk = ~clk;

    can_frame_err_irq i_can_frame_err_irq (
        .clk(clk), .rst_n(rst_n), .berr_evt(berr_evt), .berr_code(berr_code),
        .arb_lost_evt(arb_lost_evt), .warn_evt(warn_evt), .passive_evt(passive_evt),
        .busoff_evt(busoff_evt), .rx_sof(rx_sof), .prebuf_full(prebuf_full),
        .rx_drop(rx_drop), .reg_cs(reg_cs), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return {2'b00, m_st};
            2'd1: return {2'b00, m_en};
            2'd2: return {3'b000, m_irq, 4'b0000};
            default: return m_cap;
        endcase
    endfunction

    function automatic string read_req(input logic [1:0] a);
        case (a)
            2'd0: return "R1/R3";
            2'd1: return "R11";
            2'd2: return "R4";
            default: return "R6";
        endcase
    endfunction

    // one cycle: ev = {busoff, passive, berr, warn, arb}
    task automatic step(input logic [4:0] ev, input logic [7:0] code, input logic sof,
                        input logic full, input logic cs, input logic wr,
                        input logic [1:0] addr, input logic [7:0] wd);
        logic [5:0] set;
        logic       rd_cap, lk;
        @(negedge clk);
        {busoff_evt, passive_evt, berr_evt, warn_evt, arb_lost_evt} = ev;
        berr_code = code; rx_sof = sof; prebuf_full = full;
        reg_cs = cs; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        #1;
        if (cs && !wr) check(read_req(addr), reg_rdata, exp_read(addr));
        set = {ev[4], ev[3], ev[2], ev[1], ev[0], sof && full};
        rd_cap = cs && !wr && (addr == 2'd3);
        if (cs && wr && addr == 2'd0) m_st = m_st & ~(wd[5:0] & 6'b110111);
        if (rd_cap) m_st[3] = 1'b0;
        if (cs && wr && addr == 2'd2 && wd[4] && m_st == 6'd0 && (m_st | ~m_st) != 0) begin
        end
        begin
            logic clr_ok;
            clr_ok = cs && wr && addr == 2'd2 && wd[4] && ({m_st} == 6'd0);
            // clearing gate uses flags before this cycle's updates
            clr_ok = clr_ok;
            if (clr_ok_prev_gate(cs, wr, addr, wd)) m_irq = 1'b0;
        end
        if ((set & m_en) != 0) m_irq = 1'b1;
        m_st = m_st | set;
        if (cs && wr && addr == 2'd1) m_en = wd[5:0];
        lk = m_lock && !rd_cap;
        m_lock = lk;
        if (ev[2] && !lk) begin
            m_cap = code;
            m_lock = 1'b1;
        end
        if (sof) m_drop = full;
        @(posedge clk);
        #1;
        check("R2/R4 irq", {7'd0, irq}, {7'd0, m_irq});
        check("R9 rx_drop", {7'd0, rx_drop}, {7'd0, m_drop});
        g_st_pre = m_st;
    endtask

    // flags as they stood before the current cycle
    logic [5:0] g_st_pre = '0;
    function automatic bit clr_ok_prev_gate(input logic cs, input logic wr,
                                            input logic [1:0] addr, input logic [7:0] wd);
        return cs && wr && addr == 2'd2 && wd[4] && (g_st_pre == 6'd0);
    endfunction

    task automatic idle();
        step(5'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic rd(input logic [1:0] a);
        step(5'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, a, 8'h00);
    endtask

    task automatic wrr(input logic [1:0] a, input logic [7:0] d);
        step(5'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, a, d);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] seen;
        m_st = '0; m_en = '0; m_irq = 1'b0; m_lock = 1'b0; m_drop = 1'b0; m_cap = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state
        check("R10 irq", {7'd0, irq}, 8'd0);
        check("R10 rx_drop", {7'd0, rx_drop}, 8'd0);
        rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd3);

        // R11 enable readback, R2 enabled event
        wrr(2'd1, 8'h3f);
        rd(2'd1);
        // R6 capture: form error, receive, data length code = 01_1_01011
        step(5'b00100, 8'h6B, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        check("R2 irq after enabled bus error", {7'd0, irq}, 8'd1);
        // R7 second error while locked: stuff, tx, ack slot = 10_0_11001
        step(5'b00100, 8'h99, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        // R3 writing bit 3 has no effect
        wrr(2'd0, 8'h08);
        rd(2'd0);
        // R4 clear attempt with flag set keeps irq
        wrr(2'd2, 8'h10);
        check("R4 irq held while flag set", {7'd0, irq}, 8'd1);
        // R8 read and new error together: other, rx, overload = 11_1_11100
        @(negedge clk);
        step(5'b00100, 8'hFC, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 8'h00);
        rd(2'd0);
        // R5 read clears flag; R7 code kept was 6B, now FC captured
        rd(2'd3);
        check("R8 captured code after joint read", m_cap, 8'hFC);
        rd(2'd0);
        // R4 two-step clear now succeeds
        wrr(2'd2, 8'h10);
        check("R4 irq cleared after flags clear", {7'd0, irq}, 8'd0);
        // R9 overflow then recovery
        step(5'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
        check("R9 drop raised", {7'd0, rx_drop}, 8'd1);
        idle();
        step(5'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        check("R9 drop cleared", {7'd0, rx_drop}, 8'd0);
        // R3 w1c with hw set same cycle wins
        step(5'b00001, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 8'h3f);
        rd(2'd0);
        // R2 disabled event does not raise irq
        wrr(2'd0, 8'h37);
        wrr(2'd2, 8'h10);
        wrr(2'd1, 8'h00);
        step(5'b10010, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        check("R2 no irq when disabled", {7'd0, irq}, 8'd0);
        rd(2'd0);
        seen = reg_rdata;

        // random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 600; i++) begin
            logic [4:0] ev;
            logic [7:0] code, wd;
            logic       sof, full, cs, wr;
            logic [1:0] addr;
            ev   = 5'd0;
            for (int b = 0; b < 5; b++) ev[b] = ($urandom % 8) == 0;
            code = 8'($urandom);
            sof  = ($urandom % 6) == 0;
            full = ($urandom % 2) == 0;
            cs   = ($urandom % 2) == 0;
            wr   = ($urandom % 2) == 0;
            addr = 2'($urandom);
            wd   = 8'($urandom);
            if (addr == 2'd2 && wr) wd[4] = 1'b1;
            step(ev, code, sof, full, cs, wr, addr, wd);
        end
        for (int a = 0; a < 4; a++) rd(2'(a));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule